// File: doc/BRIEF.md
# System Management Interrupt Aggregator

This block merges interrupt events from peripheral devices, general-purpose input pins and two port-style event lines into one group system-management interrupt. Every event has a status bit and an enable bit. The group interrupt is the OR of all enabled status contributions. It is registered once and then routed through two master gates. One gate drives a pin with programmable polarity and buffer mode. The other raises a request flag for one slot of a serial IRQ stream.

All event inputs are asynchronous and are synchronized inside the block. The sources do not share one clearing rule. Device events are plain levels that are cleared at their source. The infrared event is latched and clears when its status byte is read. Pin and port events are edge-captured and software clears them by writing 1. Software reaches every register through a byte-wide synchronous register port. Read data appears one cycle after the read strobe.

Top module: `smi_aggregator`

## Requirements
- R1: After reset all enable, polarity, both-edge and output-config bytes read 0. All status is clear, `serirq_req` is 0, and the pin is idle in open-drain active-low form (`smi_pin_oe`=0, `smi_pin_out`=0).
- R2: Register addresses are: 0 device status, 1 device enable, 2 aux status, 3 aux enable, 4 pin status, 5 pin enable, 6 pin polarity, 7 pin both-edge, 8 output config. A write sets the register in the next cycle. `reg_rdata` holds the addressed byte from the cycle after `reg_rd`.
- R3: Device status bit i reads the synchronized level of `dev_evt[i]`. Writing to the device status byte has no effect. Each device level ANDed with its device enable bit contributes to the group interrupt.
- R4: Aux status bit 0 latches on a rising edge of `ir_evt`. A falling edge does not set it. A read of address 2 returns the bit and then clears it. Its enable is aux enable bit 0.
- R5: With pin polarity bit i at 0, a rising edge of `gpio_evt[i]` sets pin status bit i and a falling edge does not. With the polarity bit at 1 the roles of the two edges are swapped.
- R6: With pin both-edge bit i at 1, either edge of `gpio_evt[i]` sets pin status bit i, whatever the polarity bit holds.
- R7: Writing 1 to a pin status bit clears it. Writing 0 leaves it set. A held pin status bit ANDed with pin enable bit i keeps the group interrupt asserted.
- R8: Aux status bit 1 (port A) sets on a falling edge of `port_a_evt` by default. It sets on either edge when output-config bit 2 is 1. Its contribution (aux enable bit 1) stays asserted until software writes 1 to aux status bit 1.
- R9: Aux status bit 2 (port B) sets on a falling edge of `port_b_evt` by default and then contributes a held level (aux enable bit 2) until cleared by writing 1. When output-config bit 3 is 1, either edge sets it, and each edge adds exactly one clock of group interrupt while the status bit stays latched.
- R10: The group interrupt is the registered OR of all enabled contributions. A device level change reaches it on the third rising clock edge after the input changes.
- R11: `serirq_req` equals the group interrupt gated by aux enable bit 6. The pin is active only when the group interrupt is set and aux enable bit 7 is 1.
- R12: Output-config bit 0 selects an active-high pin and bit 1 selects push-pull. In open-drain mode `smi_pin_out` holds the active level and `smi_pin_oe` follows the active state. In push-pull mode `smi_pin_oe` is 1 and `smi_pin_out` carries the active or inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_evt | input | N_DEV | Peripheral device event levels |
| ir_evt | input | 1 | Infrared event line |
| port_a_evt | input | 1 | Port event A line |
| port_b_evt | input | 1 | Port event B line |
| gpio_evt | input | N_GPIO | General-purpose pin event lines |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after the read |
| smi_pin_out | output | 1 | Interrupt pin data |
| smi_pin_oe | output | 1 | Interrupt pin output enable |
| serirq_req | output | 1 | Request flag for the serial IRQ slot |

## Verification
The hardest case to reach from the ports is port B in both-edge mode. There, the status bit is already latched and the only visible trace of a new edge is a one-clock pulse on the group interrupt. The stimulus first clears every other source. It then toggles `port_b_evt` and counts the cycles `serirq_req` is high over a window longer than the synchronizer delay. Exactly one cycle is expected per edge, and the status bit must read back as set. The pin-edge rules are swept over every pin bit, both polarities, both edge modes and both edge directions.

// File: rtl/smi_pkg.sv
package smi_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_DEV_STS = 4'd0,
        A_DEV_EN  = 4'd1,
        A_AUX_STS = 4'd2,
        A_AUX_EN  = 4'd3,
        A_GP_STS  = 4'd4,
        A_GP_EN   = 4'd5,
        A_GP_POL  = 4'd6,
        A_GP_BOTH = 4'd7,
        A_OUT_CFG = 4'd8
    } reg_addr_e;

    // aux status / enable bit positions
    localparam int AUX_IR    = 0;
    localparam int AUX_PA    = 1;
    localparam int AUX_PB    = 2;
    localparam int GATE_SIRQ = 6;
    localparam int GATE_PIN  = 7;

    // output config bit positions
    localparam int CFG_ACT_HIGH  = 0;
    localparam int CFG_PUSH_PULL = 1;
    localparam int CFG_PA_BOTH   = 2;
    localparam int CFG_PB_BOTH   = 3;
    localparam int CFG_W         = 4;
endpackage

// File: rtl/smi_sync.sv
module smi_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/smi_edge.sv
module smi_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = level;
        hit    = (level & ~prev_q & rise_en) | (~level & prev_q & fall_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/smi_pin.sv
module smi_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic smi,
    input  logic gate,
    input  logic act_high,
    input  logic push_pull,
    output logic pin_out,
    output logic pin_oe
);
    logic active;

    always_comb begin
        active = smi & gate;
        if (push_pull) begin
            pin_oe  = 1'b1;
            pin_out = active ? act_high : ~act_high;
        end else begin
            pin_oe  = active;
            pin_out = act_high;
        end
    end

    // push-pull always drives the pad
    p_pp_drives_r12: assert property (@(posedge clk) disable iff (!rst_n)
        push_pull |-> pin_oe);

    // open-drain data sits at the active level
    p_od_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !push_pull |-> (pin_out == act_high));
endmodule

// File: rtl/smi_aggregator.sv
module smi_aggregator
    import smi_pkg::*;
#(
    parameter int N_DEV       = 6,   // 1..8
    parameter int N_GPIO      = 8,   // 1..8
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_DEV-1:0]  dev_evt,
    input  logic              ir_evt,
    input  logic              port_a_evt,
    input  logic              port_b_evt,
    input  logic [N_GPIO-1:0] gpio_evt,
    input  logic [3:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              smi_pin_out,
    output logic              smi_pin_oe,
    output logic              serirq_req
);
    localparam int E_W  = N_GPIO + 3;
    localparam int E_IR = N_GPIO;
    localparam int E_PA = N_GPIO + 1;
    localparam int E_PB = N_GPIO + 2;

    typedef struct packed {
        logic [N_DEV-1:0]  dev_en;
        logic [7:0]        aux_en;
        logic [N_GPIO-1:0] gp_en;
        logic [N_GPIO-1:0] gp_pol;
        logic [N_GPIO-1:0] gp_both;
        logic [N_GPIO-1:0] gp_sts;
        logic [CFG_W-1:0]  out_cfg;
        logic              sts_ir;
        logic              sts_pa;
        logic              sts_pb;
        logic [7:0]        rdata;
        logic              smi;
    } state_t;

    state_t state_d, state_q;

    logic [N_DEV-1:0]  dev_sync;
    logic [E_W-1:0]    edge_sync, rise_en, fall_en, edge_hit;
    logic [N_GPIO-1:0] gp_hit, gp_clr;
    logic              ir_hit, pa_hit, pb_hit;
    reg_addr_e         addr;

    assign addr = reg_addr_e'(reg_addr);

    smi_sync #(.W(N_DEV), .STAGES(SYNC_STAGES)) u_dev_sync (
        .clk(clk), .rst_n(rst_n), .async_in(dev_evt), .sync_out(dev_sync));

    smi_sync #(.W(E_W), .STAGES(SYNC_STAGES)) u_edge_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({port_b_evt, port_a_evt, ir_evt, gpio_evt}),
        .sync_out(edge_sync));

    always_comb begin
        rise_en = {state_q.out_cfg[CFG_PB_BOTH], state_q.out_cfg[CFG_PA_BOTH],
                   1'b1, ~state_q.gp_pol | state_q.gp_both};
        fall_en = {1'b1, 1'b1, 1'b0, state_q.gp_pol | state_q.gp_both};
    end

    smi_edge #(.W(E_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .level(edge_sync),
        .rise_en(rise_en), .fall_en(fall_en), .hit(edge_hit));

    assign gp_hit = edge_hit[N_GPIO-1:0];
    assign ir_hit = edge_hit[E_IR];
    assign pa_hit = edge_hit[E_PA];
    assign pb_hit = edge_hit[E_PB];

    always_comb begin
        logic [7:0] rd_byte;
        logic       aux_wr, pb_term;
        state_d = state_q;

        // configuration writes
        if (reg_wr) begin
            case (addr)
                A_DEV_EN:  state_d.dev_en  = reg_wdata[N_DEV-1:0];
                A_AUX_EN:  state_d.aux_en  = reg_wdata;
                A_GP_EN:   state_d.gp_en   = reg_wdata[N_GPIO-1:0];
                A_GP_POL:  state_d.gp_pol  = reg_wdata[N_GPIO-1:0];
                A_GP_BOTH: state_d.gp_both = reg_wdata[N_GPIO-1:0];
                A_OUT_CFG: state_d.out_cfg = reg_wdata[CFG_W-1:0];
                default: ;
            endcase
        end

        // status: clear first, a new event in the same cycle wins
        gp_clr  = (reg_wr && addr == A_GP_STS) ? reg_wdata[N_GPIO-1:0] : '0;
        aux_wr  = reg_wr && addr == A_AUX_STS;
        state_d.gp_sts = (state_q.gp_sts & ~gp_clr) | gp_hit;
        state_d.sts_pa = (state_q.sts_pa & ~(aux_wr & reg_wdata[AUX_PA])) | pa_hit;
        state_d.sts_pb = (state_q.sts_pb & ~(aux_wr & reg_wdata[AUX_PB])) | pb_hit;
        state_d.sts_ir = (state_q.sts_ir & ~(reg_rd && addr == A_AUX_STS)) | ir_hit;

        // read mux
        rd_byte = '0;
        case (addr)
            A_DEV_STS: rd_byte[N_DEV-1:0]  = dev_sync;
            A_DEV_EN:  rd_byte[N_DEV-1:0]  = state_q.dev_en;
            A_AUX_STS: begin
                rd_byte[AUX_IR] = state_q.sts_ir;
                rd_byte[AUX_PA] = state_q.sts_pa;
                rd_byte[AUX_PB] = state_q.sts_pb;
            end
            A_AUX_EN:  rd_byte             = state_q.aux_en;
            A_GP_STS:  rd_byte[N_GPIO-1:0] = state_q.gp_sts;
            A_GP_EN:   rd_byte[N_GPIO-1:0] = state_q.gp_en;
            A_GP_POL:  rd_byte[N_GPIO-1:0] = state_q.gp_pol;
            A_GP_BOTH: rd_byte[N_GPIO-1:0] = state_q.gp_both;
            A_OUT_CFG: rd_byte[CFG_W-1:0]  = state_q.out_cfg;
            default: ;
        endcase
        if (reg_rd) state_d.rdata = rd_byte;

        // group interrupt: port B in both-edge mode contributes a pulse
        pb_term = state_q.out_cfg[CFG_PB_BOTH] ? pb_hit : state_q.sts_pb;
        state_d.smi = (|(dev_sync & state_q.dev_en))
                    | (state_q.sts_ir & state_q.aux_en[AUX_IR])
                    | (state_q.sts_pa & state_q.aux_en[AUX_PA])
                    | (pb_term        & state_q.aux_en[AUX_PB])
                    | (|(state_q.gp_sts & state_q.gp_en));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign reg_rdata  = state_q.rdata;
    assign serirq_req = state_q.smi & state_q.aux_en[GATE_SIRQ];

    smi_pin u_pin (
        .clk(clk), .rst_n(rst_n), .smi(state_q.smi),
        .gate(state_q.aux_en[GATE_PIN]),
        .act_high(state_q.out_cfg[CFG_ACT_HIGH]),
        .push_pull(state_q.out_cfg[CFG_PUSH_PULL]),
        .pin_out(smi_pin_out), .pin_oe(smi_pin_oe));

    // a read of aux status drops the infrared bit unless a new edge arrives
    p_ir_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && addr == A_AUX_STS && !ir_hit) |=> !state_q.sts_ir);

    // ones written to pin status are gone next cycle unless re-hit
    p_gpio_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && addr == A_GP_STS) |=>
        ((state_q.gp_sts & $past(reg_wdata[N_GPIO-1:0] & ~gp_hit)) == '0));

    // the group interrupt never rises with every enable clear
    p_smi_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.smi) |->
        $past((|state_q.dev_en) || (|state_q.aux_en[AUX_PB:AUX_IR]) || (|state_q.gp_en)));

    // both gates open: serial request and active pin agree
    p_gates_agree_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (serirq_req && state_q.aux_en[GATE_PIN]) |->
        (smi_pin_oe && smi_pin_out == state_q.out_cfg[CFG_ACT_HIGH]));
endmodule

// File: tb/smi_aggregator_bench.sv
module smi_aggregator_bench;
    localparam int ND = 6;
    localparam int NG = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [ND-1:0] dev_evt;
    logic          ir_evt, port_a_evt, port_b_evt;
    logic [NG-1:0] gpio_evt;
    logic [3:0]    reg_addr;
    logic          reg_wr, reg_rd;
    logic [7:0]    reg_wdata, reg_rdata;
    logic          smi_pin_out, smi_pin_oe, serirq_req;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    smi_aggregator #(.N_DEV(ND), .N_GPIO(NG)) u_smi_aggregator (
        .clk(clk), .rst_n(rst_n), .dev_evt(dev_evt), .ir_evt(ir_evt),
        .port_a_evt(port_a_evt), .port_b_evt(port_b_evt), .gpio_evt(gpio_evt),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .smi_pin_out(smi_pin_out), .smi_pin_oe(smi_pin_oe), .serirq_req(serirq_req));

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_addr = 4'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_addr = 4'(a); reg_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
        d = int'(reg_rdata);
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic count_smi(output int n);
        n = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (serirq_req) n++;
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int v, n;
        dev_evt = '0; ir_evt = 0; port_a_evt = 0; port_b_evt = 0; gpio_evt = '0;
        reg_addr = '0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 serirq_req", int'(serirq_req), 0);
        chk("R1 pin_oe", int'(smi_pin_oe), 0);
        chk("R1 pin_out", int'(smi_pin_out), 0);
        for (int a = 0; a <= 8; a++) begin
            rd(a, v);
            chk($sformatf("R1 reg %0d", a), v, 0);
        end

        // R2 write/readback on config registers
        wr(1, 8'h2A); rd(1, v); chk("R2 dev_en", v, 8'h2A);
        wr(5, 8'hC3); rd(5, v); chk("R2 gp_en", v, 8'hC3);
        wr(6, 8'h5A); rd(6, v); chk("R2 gp_pol", v, 8'h5A);
        wr(7, 8'hA5); rd(7, v); chk("R2 gp_both", v, 8'hA5);
        wr(8, 8'h0F); rd(8, v); chk("R2 out_cfg", v, 8'h0F);
        wr(3, 8'h40); rd(3, v); chk("R2 aux_en", v, 8'h40);
        wr(1, 0); wr(5, 0); wr(6, 0); wr(7, 0); wr(8, 0);
        settle(); wr(4, 8'hFF); wr(2, 8'hFF); rd(2, v);

        // R3 / R10 device sweep, serial gate open
        for (int p = 0; p < 64; p++) begin
            for (int e = 0; e < 4; e++) begin
                int en;
                en = (e == 0) ? 8'h3F : (e == 1) ? 8'h15 : (e == 2) ? 8'h2A : 0;
                wr(1, en);
                dev_evt = 6'(p);
                settle();
                chk($sformatf("R3 R10 dev p=%0h en=%0h", p, en),
                    int'(serirq_req), ((p & en) != 0) ? 1 : 0);
            end
            rd(0, v);
            chk("R3 dev status", v, p);
        end
        dev_evt = 6'h3F; settle();
        wr(0, 8'hFF); rd(0, v); chk("R3 write ignored", v, 8'h3F);
        dev_evt = '0; wr(1, 0); settle();

        // R10 exact latency
        wr(1, 1);
        @(negedge clk); dev_evt = 6'h01;
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R10 latency before", int'(serirq_req), 0);
        @(posedge clk); @(negedge clk);
        chk("R10 latency at", int'(serirq_req), 1);
        dev_evt = '0; wr(1, 0); settle();

        // R5 R6 R7 pin edge sweep
        for (int i = 0; i < NG; i++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int both = 0; both < 2; both++) begin
                    for (int up = 0; up < 2; up++) begin
                        int exp;
                        gpio_evt[i] = (up == 1) ? 1'b0 : 1'b1;
                        settle();
                        wr(6, pol << i); wr(7, both << i);
                        wr(4, 8'hFF); wr(5, 1 << i);
                        settle();
                        chk("R7 cleared before edge", int'(serirq_req), 0);
                        gpio_evt[i] = (up == 1) ? 1'b1 : 1'b0;
                        settle();
                        exp = (both == 1) ? 1 : ((up == 1) ? (pol == 0 ? 1 : 0) : pol);
                        rd(4, v);
                        chk($sformatf("R5 R6 bit=%0d pol=%0d both=%0d up=%0d", i, pol, both, up),
                            v, exp << i);
                        chk("R7 held contribution", int'(serirq_req), exp);
                        wr(4, 0); rd(4, v);
                        chk("R7 write zero keeps", v, exp << i);
                        wr(4, 1 << i); settle(); rd(4, v);
                        chk("R7 write one clears", v, 0);
                        chk("R7 smi drops", int'(serirq_req), 0);
                    end
                end
            end
            gpio_evt[i] = 1'b0; settle(); wr(4, 8'hFF);
        end
        wr(5, 0); wr(6, 0); wr(7, 0); settle(); wr(4, 8'hFF);

        // R4 infrared latch, clear on read
        wr(3, 8'h41);
        ir_evt = 1; settle();
        chk("R4 smi on rise", int'(serirq_req), 1);
        wr(2, 8'h01); rd(2, v); chk("R4 write no effect", v, 1);
        rd(2, v); chk("R4 read cleared", v, 0);
        settle(); chk("R4 smi gone", int'(serirq_req), 0);
        ir_evt = 0; settle(); rd(2, v); chk("R4 fall ignored", v, 0);

        // R8 port A
        wr(3, 8'h42);
        port_a_evt = 1; settle(); rd(2, v); chk("R8 rise ignored default", v, 0);
        port_a_evt = 0; settle(); rd(2, v); chk("R8 fall sets", v, 2);
        repeat (20) @(posedge clk); @(negedge clk);
        chk("R8 held", int'(serirq_req), 1);
        wr(2, 2); settle(); rd(2, v); chk("R8 w1c", v, 0);
        chk("R8 released", int'(serirq_req), 0);
        wr(8, 8'h04);
        port_a_evt = 1; settle(); rd(2, v); chk("R8 both rise", v, 2);
        wr(2, 2); port_a_evt = 0; settle(); rd(2, v); chk("R8 both fall", v, 2);
        wr(2, 2); wr(8, 0); settle();

        // R9 port B
        wr(3, 8'h44);
        port_b_evt = 1; settle(); rd(2, v); chk("R9 rise ignored default", v, 0);
        port_b_evt = 0; settle(); rd(2, v); chk("R9 fall sets", v, 4);
        count_smi(n); chk("R9 held level", n, 10);
        wr(2, 4); settle(); chk("R9 released", int'(serirq_req), 0);
        wr(8, 8'h08); settle();
        @(negedge clk); port_b_evt = 1;
        count_smi(n); chk("R9 pulse on rise", n, 1);
        rd(2, v); chk("R9 latched after rise", v, 4);
        @(negedge clk); port_b_evt = 0;
        count_smi(n); chk("R9 pulse on fall", n, 1);
        rd(2, v); chk("R9 still latched", v, 4);
        wr(2, 4); wr(8, 0); wr(3, 0); settle();

        // R11 R12 gates and pin shaping
        wr(1, 1);
        for (int s = 0; s < 2; s++) begin
            dev_evt = 6'(s);
            for (int g = 0; g < 4; g++) begin
                for (int c = 0; c < 4; c++) begin
                    int act, ah, pp;
                    wr(3, g << 6); wr(8, c); settle();
                    ah = c & 1; pp = (c >> 1) & 1;
                    act = s & (g >> 1);
                    chk($sformatf("R11 serirq s=%0d g=%0d", s, g), int'(serirq_req), s & g & 1);
                    chk($sformatf("R12 oe s=%0d g=%0d c=%0d", s, g, c), int'(smi_pin_oe),
                        pp ? 1 : act);
                    chk($sformatf("R12 out s=%0d g=%0d c=%0d", s, g, c), int'(smi_pin_out),
                        pp ? (act ? ah : 1 - ah) : ah);
                end
            end
        end

        summary();
    end
endmodule